// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A processor-facing parallel I/O device. It has three 8-bit ports, A, B and C, and one control location. These sit behind a small bus made of chip select, read strobe, write strobe, a 2-bit address and separate data-in and data-out lines. The data-out lines come with a valid flag.

A mode word sets the direction of port A, port B, the upper half of port C and the lower half of port C. A second form of control write, the single-line command, sets or clears one port C output bit and leaves the others alone. Output values are held in per-port latches. Each pin has its own output enable, and the pad itself is outside the block. Inputs are read live from the pins.

Every access takes one clock. A write is captured on the rising edge while chip select and the write strobe are both high. A read is combinational while chip select and the read strobe are both high.

Top module: `ppio_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, before any control write: every output enable is 0, all three output latches are 0, and a read of address 3 returns 0x9B. 0x9B is the mode word that makes every port an input.
- R2: A read requires `cs` and `rd` both high. `dout_valid` is 1 exactly then, and `dout` is 0 otherwise. Address 0 reads port A, 1 reads port B, 2 reads port C and 3 reads the control word.
- R3: A write of a byte with bit 7 = 1 to address 3 is a mode word. It is stored and read back unchanged at address 3. Its direction bits use 1 = input and 0 = output: bit 4 is port A, bit 3 is PC7..PC4, bit 1 is port B, and bit 0 is PC3..PC0.
- R4: A write of a byte with bit 7 = 0 to address 3 is a single-line command. Bits 3..1 name the port C line (0 = PC0 through 7 = PC7) and bit 0 is its new latch value. Bits 6..4 have no effect. No other port C latch bit changes.
- R5: A single-line command changes neither the stored mode word nor any output enable.
- R6: On an output port (or port C half), every output enable bit is 1. The pins carry the latch value, and a read returns the latch value.
- R7: On an input port (or port C half), every output enable bit is 0 and a read returns the live pin value.
- R8: A write to an input port updates its latch without enabling any output. The value appears once the port is later made an output.
- R9: A write has effect only with `cs` and `wr` both high in the same cycle. Otherwise the latches and the mode word keep their values.
- R10: Mode word 0x89 gives A and B as outputs and all of port C as input. Mode word 0x9A gives A, B and PC7..PC4 as inputs and PC3..PC0 as output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Location: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_valid | output | 1 | Read data valid |
| pa_pin | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch value |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_pin | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch value |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_pin | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch value |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench steps through all 16 combinations of the four direction bits. For each it loads distinct latch values and drives distinct pin values, so every read shows whether it came from a latch or from the pins. It also shows whether the port C halves were decoded separately.

Every single-line command is tried: all eight lines, both values, and varied junk in bits 6..4. Each result is compared with a running model of port C, which exposes any write to a neighbouring bit or any misuse of the ignored bits. Writes to input ports, and strobes that arrive without chip select, are then made visible by switching the ports to output and reading back.

// File: rtl/ppio_ctrl.sv
module ppio_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_valid,
  input  logic [7:0] pa_pin,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_pin,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_pin,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam logic [7:0] ALL_INPUT = 8'h9B;

  logic [7:0] mode_q, pa_q, pb_q, pc_q;
  logic [7:0] rd_mux;
  logic       wr_en, rd_en;

  assign wr_en = cs & wr;
  assign rd_en = cs & rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ALL_INPUT;
      pa_q   <= '0;
      pb_q   <= '0;
      pc_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: pa_q <= din;
        2'd1: pb_q <= din;
        2'd2: pc_q <= din;
        default: begin
          if (din[7]) mode_q <= din;
          else        pc_q[din[3:1]] <= din[0];
        end
      endcase
    end
  end

  assign pa_oe  = {8{~mode_q[4]}};
  assign pb_oe  = {8{~mode_q[1]}};
  assign pc_oe  = {{4{~mode_q[3]}}, {4{~mode_q[0]}}};
  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;

  always_comb begin
    case (addr)
      2'd0:    rd_mux = (pa_oe & pa_q) | (~pa_oe & pa_pin);
      2'd1:    rd_mux = (pb_oe & pb_q) | (~pb_oe & pb_pin);
      2'd2:    rd_mux = (pc_oe & pc_q) | (~pc_oe & pc_pin);
      default: rd_mux = mode_q;
    endcase
  end

  assign dout       = rd_en ? rd_mux : 8'h00;
  assign dout_valid = rd_en;
endmodule

module ppio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       dout_valid,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
             pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |-> (!dout_valid && dout == 8'h00));

  // R3
  ctl_read_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'd3) |-> dout[7]);

  // R4
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !din[7]) |=>
      ($countones(pc_out ^ $past(pc_out)) <= 1 && pc_out[$past(din[3:1])] == $past(din[0])));

  // R5
  single_line_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !din[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out) && $stable(pb_out)));

  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                     $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .din(din),
  .dout(dout), .dout_valid(dout_valid), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppio_ctrl_test.sv
`timescale 1ns/1ps
module ppio_ctrl_test;
  logic clk = 0, rst = 1, cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, pa_pin = 0, pb_pin = 0, pc_pin = 0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic dout_valid;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ppio_ctrl uut (.clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .din(din),
    .dout(dout), .dout_valid(dout_valid), .pa_pin(pa_pin), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_pin(pb_pin), .pb_out(pb_out), .pb_oe(pb_oe), .pc_pin(pc_pin), .pc_out(pc_out),
    .pc_oe(pc_oe));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d, logic c = 1, logic w = 1);
    @(negedge clk);
    cs = c; wr = w; addr = a; din = d;
    @(posedge clk); #1;
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 d = dout;
    check("R2 valid", {7'd0, dout_valid}, 8'h01);
    @(posedge clk); #1;
    cs = 0; rd = 0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, pcm, word;
    logic ai, bi, ui, li;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pa_oe", pa_oe, 0); check("R1 pb_oe", pb_oe, 0); check("R1 pc_oe", pc_oe, 0);
    check("R1 latch", pa_out | pb_out | pc_out, 0);
    @(negedge clk); rst = 0;
    check("R2 idle dout", dout, 0);
    check("R2 idle valid", {7'd0, dout_valid}, 0);
    bus_rd(2'd3, v); check("R1 ctl", v, 8'h9B);

    for (int i = 0; i < 16; i++) begin
      ai = i[3]; ui = i[2]; bi = i[1]; li = i[0];
      word = {1'b1, 2'b00, ai, ui, 1'b0, bi, li};
      bus_wr(2'd3, word);
      bus_wr(2'd0, 8'h11 + 8'(i)); bus_wr(2'd1, 8'h62 ^ 8'(i)); bus_wr(2'd2, 8'hC3 - 8'(i));
      pa_pin = 8'hF0 ^ 8'(i); pb_pin = 8'h0F + 8'(i); pc_pin = 8'hA5 ^ 8'(i * 3);
      #1;
      check("R3 pa_oe", pa_oe, ai ? 8'h00 : 8'hFF);
      check("R3 pb_oe", pb_oe, bi ? 8'h00 : 8'hFF);
      check("R3 pc_oe", pc_oe, {{4{~ui}}, {4{~li}}});
      bus_rd(2'd3, v); check("R3 readback", v, word);
      bus_rd(2'd0, v); check(ai ? "R7 A" : "R6 A", v, ai ? pa_pin : 8'h11 + 8'(i));
      bus_rd(2'd1, v); check(bi ? "R7 B" : "R6 B", v, bi ? pb_pin : 8'h62 ^ 8'(i));
      bus_rd(2'd2, v);
      check("R6 R7 C", v, {ui ? pc_pin[7:4] : 4'(8'hC3 - 8'(i) >> 4), li ? pc_pin[3:0] : 4'(8'hC3 - 8'(i))});
      check("R6 latch A", pa_out, 8'h11 + 8'(i));
    end

    bus_wr(2'd3, 8'h89);
    check("R10 89 A", pa_oe, 8'hFF); check("R10 89 B", pb_oe, 8'hFF); check("R10 89 C", pc_oe, 8'h00);
    bus_wr(2'd3, 8'h9A);
    check("R10 9A A", pa_oe, 8'h00); check("R10 9A B", pb_oe, 8'h00); check("R10 9A C", pc_oe, 8'h0F);

    bus_wr(2'd3, 8'h80);
    bus_wr(2'd2, 8'h00); pcm = 8'h00;
    for (int k = 0; k < 32; k++) begin
      logic [2:0] sel; logic val;
      sel = 3'(k); val = k[3] ^ k[0];
      bus_wr(2'd3, {1'b0, 3'(k * 5), sel, val});
      pcm[sel] = val;
      check("R4 pc_out", pc_out, pcm);
      check("R5 pc_oe", pc_oe, 8'hFF);
    end
    bus_rd(2'd3, v); check("R5 mode kept", v, 8'h80);

    bus_wr(2'd3, 8'h92);
    bus_wr(2'd0, 8'h3C);
    check("R8 no drive", pa_oe, 8'h00);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd0, v); check("R8 latched", v, 8'h3C);

    bus_wr(2'd0, 8'hE7, 1'b0, 1'b1);
    bus_wr(2'd0, 8'hE7, 1'b1, 1'b0);
    bus_wr(2'd3, 8'h9B, 1'b0, 1'b1);
    bus_rd(2'd0, v); check("R9 no write A", v, 8'h3C);
    bus_rd(2'd3, v); check("R9 no write ctl", v, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule